// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns bytes waiting in a small internal queue into asynchronous serial frames on one output line. Every frame begins with a low start bit. The data bits follow, least significant bit first. An optional parity bit comes next, and the frame ends with one or two high stop bits. The line rests high between frames. A one-cycle pulse from an external rate divider paces the bits, so each bit lasts from one pulse to the next.

A set of static control inputs decides how each frame looks. These inputs set the character length (5 to 8 bits), whether a parity bit is sent, the parity sense, fixed ("stick") parity and the number of stop bits. A break input forces the line low. The block starts a frame only when both enable inputs are high. It reports whether a frame is in progress and whether the queue is full or empty. The control inputs are sampled once, when a frame is launched, so a change in the middle of a frame never affects that frame.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset `tx_line` is 1, `busy` is 0, `q_empty` is 1 and `q_full` is 0.
- R2: A frame is a 0 start bit, then the data bits LSB first, then a 1 stop bit. `tx_line` changes only in the cycle after a `baud_tick` pulse, so each bit lasts exactly one tick period.
- R3: The `char_len` field sets the number of data bits: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Data bits above the selected length are not sent.
- R4: When `par_en` is 1, one parity bit is sent right after the data bits. When `par_en` is 0, no parity bit is sent.
- R5: With `par_even`=1 the parity bit makes the count of ones in data plus parity even. With `par_even`=0 it makes that count odd.
- R6: When `par_stick`=1 and `par_en`=1, the parity bit is the constant 0 if `par_even`=1 and the constant 1 if `par_even`=0.
- R7: When `stop_two`=1, the frame carries two stop bits instead of one.
- R8: While `brk` is 1, `tx_line` is 0 in the same cycle, and no new frame is launched. Queued bytes are kept.
- R9: A frame is launched only while both `en_main` and `en_tx` are 1. Otherwise the queued bytes wait and the line stays high.
- R10: `busy` goes to 1 in the cycle after the launching tick. It goes back to 0 in the cycle after the tick that ends the last stop bit, if no further byte is launched on that tick.
- R11: The queue holds DEPTH bytes (default 4) and sends them in write order. `q_full` and `q_empty` show its fill state. A write while `q_full` is 1 is dropped.
- R12: The control inputs are captured at launch. Changing them during a frame does not alter that frame.
- R13: If a byte is waiting and the block is enabled, the tick that ends the last stop bit launches the next frame, so its start bit follows with no idle bit in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_main | input | 1 | Global enable |
| en_tx | input | 1 | Transmit enable |
| baud_tick | input | 1 | One-cycle bit-rate pulse |
| wr_valid | input | 1 | Queue write strobe |
| wr_data | input | 8 | Byte to queue |
| char_len | input | 2 | Character length code |
| par_en | input | 1 | Parity bit enable |
| par_even | input | 1 | Even parity select |
| par_stick | input | 1 | Fixed parity select |
| stop_two | input | 1 | Two stop bits select |
| brk | input | 1 | Force line low |
| tx_line | output | 1 | Serial output, idles high |
| busy | output | 1 | Frame in progress |
| q_full | output | 1 | Queue full |
| q_empty | output | 1 | Queue empty |

## Verification
Each registered bit value and the `busy` flag update in the cycle right after the clock edge that sees `baud_tick`. The queue flags update in the cycle after a write. `brk` reaches `tx_line` in the same cycle. The bench raises `baud_tick` for exactly one cycle and then waits one further idle cycle. It samples every output on a falling edge after that idle cycle, so each check sees one settled bit per tick. Back-to-back frames are checked across the shared tick, and mid-frame control changes are made right after the start bit.

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_main,
  input  logic       en_tx,
  input  logic       baud_tick,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  input  logic [1:0] char_len,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  input  logic       stop_two,
  input  logic       brk,
  output logic       tx_line,
  output logic       busy,
  output logic       q_full,
  output logic       q_empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2} st_t;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  st_t           st;
  logic [7:0]    sh;
  logic [2:0]    left;
  logic          line, pen_q, pbit_q, two_q;

  assign q_full  = (cnt == CW'(DEPTH));
  assign q_empty = (cnt == '0);
  assign busy    = (st != S_IDLE);
  assign tx_line = line & ~brk;

  wire       push      = wr_valid & ~q_full;
  wire       last_stop = (st == S_STOP1 & ~two_q) | (st == S_STOP2);
  wire       launch    = baud_tick & en_main & en_tx & ~brk & ~q_empty & (st == S_IDLE | last_stop);
  wire [7:0] masked    = mem[rp] & (8'hFF >> (2'd3 - char_len));
  wire       calc_par  = par_even ? ^masked : ~^masked;
  wire       par_bit   = par_stick ? ~par_even : calc_par;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push)   wp <= nxt(wp);
      if (launch) rp <= nxt(rp);
      cnt <= cnt + CW'(push) - CW'(launch);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      line   <= 1'b1;
      sh     <= '0;
      left   <= '0;
      pen_q  <= 1'b0;
      pbit_q <= 1'b0;
      two_q  <= 1'b0;
    end else if (launch) begin
      sh     <= masked;
      left   <= {1'b0, char_len} + 3'd4;
      pen_q  <= par_en;
      pbit_q <= par_bit;
      two_q  <= stop_two;
      line   <= 1'b0;
      st     <= S_START;
    end else if (baud_tick) begin
      case (st)
        S_START: begin
          line <= sh[0];
          sh   <= sh >> 1;
          st   <= S_DATA;
        end
        S_DATA: begin
          if (left == '0) begin
            line <= pen_q ? pbit_q : 1'b1;
            st   <= pen_q ? S_PAR : S_STOP1;
          end else begin
            line <= sh[0];
            sh   <= sh >> 1;
            left <= left - 1'b1;
          end
        end
        S_PAR: begin
          line <= 1'b1;
          st   <= S_STOP1;
        end
        S_STOP1: st <= two_q ? S_STOP2 : S_IDLE;
        S_STOP2: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_frame_tx_chk.sv
module serial_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic en_main,
  input logic en_tx,
  input logic baud_tick,
  input logic brk,
  input logic tx_line,
  input logic busy,
  input logic q_full,
  input logic q_empty
);
  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !brk) |-> tx_line);

  p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!baud_tick && !brk) |=> (brk || $stable(tx_line)));

  p_break_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !tx_line);

  p_break_no_launch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && brk) |=> !busy);

  p_enable_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(en_main && en_tx)) |=> !busy);

  p_busy_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(busy));

  p_flags_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_full && q_empty));
endmodule

bind serial_frame_tx serial_frame_tx_chk i_chk (
  .clk(clk), .rst_n(rst_n), .en_main(en_main), .en_tx(en_tx),
  .baud_tick(baud_tick), .brk(brk), .tx_line(tx_line), .busy(busy),
  .q_full(q_full), .q_empty(q_empty)
);

// File: tb/test_serial_frame_tx.sv
module test_serial_frame_tx;
  logic clk = 0, rst_n = 0;
  logic en_main = 0, en_tx = 0, baud_tick = 0, wr_valid = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] char_len = 0;
  logic par_en = 0, par_even = 0, par_stick = 0, stop_two = 0, brk = 0;
  logic tx_line, busy, q_full, q_empty;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  serial_frame_tx #(.DEPTH(4)) i_serial_frame_tx (
    .clk(clk), .rst_n(rst_n), .en_main(en_main), .en_tx(en_tx),
    .baud_tick(baud_tick), .wr_valid(wr_valid), .wr_data(wr_data),
    .char_len(char_len), .par_en(par_en), .par_even(par_even),
    .par_stick(par_stick), .stop_two(stop_two), .brk(brk),
    .tx_line(tx_line), .busy(busy), .q_full(q_full), .q_empty(q_empty)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) baud_tick = 1;
    @(negedge clk) baud_tick = 0;
    @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk) begin wr_valid = 1; wr_data = d; end
    @(negedge clk) wr_valid = 0;
  endtask

  task automatic set_cfg(input logic [1:0] l, input logic pe, ev, sk, two);
    @(negedge clk);
    char_len = l; par_en = pe; par_even = ev; par_stick = sk; stop_two = two;
  endtask

  function automatic int frame_bits(input logic [7:0] d, input logic [1:0] l,
                                    input logic pe, ev, sk, two, output logic [11:0] b);
    int n = 5 + int'(l);
    int k = 0;
    int ones = 0;
    b = '0;
    b[k] = 0; k++;
    for (int i = 0; i < n; i++) begin b[k] = d[i]; ones += int'(d[i]); k++; end
    if (pe) begin
      b[k] = sk ? !ev : (ev ? ones[0] : !ones[0]);
      k++;
    end
    b[k] = 1; k++;
    if (two) begin b[k] = 1; k++; end
    return k;
  endfunction

  task automatic expect_frame(input logic [7:0] d, input string req, input logic change_mid);
    logic [11:0] b;
    int k = frame_bits(d, char_len, par_en, par_even, par_stick, stop_two, b);
    for (int i = 0; i < k; i++) begin
      tick();
      chk(tx_line == b[i], req, tx_line, b[i]);
      chk(busy == 1'b1, "R10 busy during frame", busy, 1);
      if (change_mid && i == 0) begin
        char_len = ~char_len; par_en = ~par_en; par_even = ~par_even;
        stop_two = ~stop_two; par_stick = ~par_stick;
      end
    end
  endtask

  task automatic end_frame();
    tick();
    chk(busy == 1'b0, "R10 busy drops after stop", busy, 0);
    chk(tx_line == 1'b1, "R2 idle high after frame", tx_line, 1);
  endtask

  task automatic run_one(input logic [7:0] d, input string req);
    push(d);
    expect_frame(d, req, 1'b0);
    end_frame();
  endtask

  task automatic t_reset();
    chk(tx_line == 1, "R1 tx_line", tx_line, 1);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(q_empty == 1, "R1 q_empty", q_empty, 1);
    chk(q_full == 0, "R1 q_full", q_full, 0);
  endtask

  task automatic t_lengths();
    for (int l = 0; l < 4; l++) begin
      set_cfg(l[1:0], 0, 0, 0, 0);
      run_one(8'hA5 ^ 8'(l * 8'h11), "R3 R2 length frame");
    end
  endtask

  task automatic t_parity();
    set_cfg(2'b11, 1, 1, 0, 0); run_one(8'h07, "R4 R5 even parity");
    set_cfg(2'b11, 1, 0, 0, 0); run_one(8'h07, "R5 odd parity");
    set_cfg(2'b01, 1, 0, 0, 0); run_one(8'hC3, "R5 odd parity short char");
    set_cfg(2'b11, 1, 1, 1, 0); run_one(8'h01, "R6 stick parity zero");
    set_cfg(2'b11, 1, 0, 1, 0); run_one(8'h03, "R6 stick parity one");
    set_cfg(2'b11, 0, 1, 0, 0); run_one(8'h01, "R4 no parity bit");
  endtask

  task automatic t_two_stop();
    set_cfg(2'b10, 1, 1, 0, 1); run_one(8'h55, "R7 two stop bits");
    set_cfg(2'b00, 0, 0, 0, 1); run_one(8'h1F, "R7 two stop bits 5-bit");
  endtask

  task automatic t_enables();
    set_cfg(2'b11, 0, 0, 0, 0);
    en_tx = 0;
    push(8'h3C);
    for (int i = 0; i < 3; i++) tick();
    chk(busy == 0, "R9 no launch without en_tx", busy, 0);
    chk(tx_line == 1, "R9 line high without en_tx", tx_line, 1);
    chk(q_empty == 0, "R9 byte held", q_empty, 0);
    en_tx = 1; en_main = 0;
    for (int i = 0; i < 3; i++) tick();
    chk(busy == 0, "R9 no launch without en_main", busy, 0);
    en_main = 1;
    expect_frame(8'h3C, "R9 held byte sent", 1'b0);
    end_frame();
  endtask

  task automatic t_break();
    @(negedge clk) brk = 1;
    @(negedge clk);
    chk(tx_line == 0, "R8 break low", tx_line, 0);
    push(8'h81);
    for (int i = 0; i < 3; i++) tick();
    chk(busy == 0, "R8 no launch in break", busy, 0);
    chk(q_empty == 0, "R8 byte kept", q_empty, 0);
    chk(tx_line == 0, "R8 line held low", tx_line, 0);
    @(negedge clk) brk = 0;
    @(negedge clk);
    chk(tx_line == 1, "R8 break released", tx_line, 1);
    expect_frame(8'h81, "R8 byte after break", 1'b0);
    end_frame();
  endtask

  task automatic t_queue();
    set_cfg(2'b11, 1, 0, 0, 0);
    for (int i = 0; i < 4; i++) push(8'(8'h10 + i));
    chk(q_full == 1, "R11 full after DEPTH writes", q_full, 1);
    push(8'hEE);
    chk(q_full == 1, "R11 full still", q_full, 1);
    for (int i = 0; i < 4; i++) expect_frame(8'(8'h10 + i), "R11 R13 fifo order back-to-back", 1'b0);
    end_frame();
    chk(q_empty == 1, "R11 dropped write absent", q_empty, 1);
  endtask

  task automatic t_midchange();
    set_cfg(2'b11, 1, 1, 0, 0);
    push(8'hD2);
    expect_frame(8'hD2, "R12 config latched", 1'b1);
    end_frame();
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    en_main = 1; en_tx = 1;
    t_lengths();
    t_parity();
    t_two_stop();
    t_enables();
    t_break();
    t_queue();
    t_midchange();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule